// File: doc/BRIEF.md
# Serial Character Transmitter with Programmable Framing

This block turns bytes into asynchronous serial frames on a single output line. A byte is handed over on a ready/valid input. The block then sends a start bit, the data bits least significant first, an optional parity bit and one, one-and-a-half or two stop bits. A line control word sets the frame shape. Its fields select the character length (5 to 8 bits), the stop bit count, whether a parity bit is sent, and the kind of parity: odd, even, or stuck at 1 or at 0.

Bit timing comes from an external enable, `baud_tick`, that pulses sixteen times per bit period. The block holds no divisor, no queue and no register interface. A break control drives the line low at any time, whatever the transmitter is doing.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, `busy` is 0 and `in_ready` is 1. While idle with no break, `txd` stays 1.
- R2: `in_ready` equals the inverse of `busy`. A byte is taken only on a clock edge where `in_valid` and `in_ready` are both 1. A byte offered while busy is ignored and produces no frame.
- R3: Every bit lasts 16 `baud_tick` pulses (24 for a one-and-a-half stop period). The line changes only on the clock edge after a tick. The start bit is 0, and the data bits follow from bit 0 upward.
- R4: `lc_wlen` selects the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits above the selected length are not sent.
- R5: With `lc_par_en` = 0 no parity bit is sent. With 1, one parity bit follows the last data bit.
- R6: `lc_par_type` selects the parity bit: 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 sends 1 and 11 sends 0.
- R7: With `lc_two_stop` = 0 the stop period is one bit of 1 (16 ticks). With 1 it is two bits (32 ticks), except that it is 1.5 bits (24 ticks) when `lc_wlen` = 00.
- R8: While `lc_break` is 1, `txd` is 0 in every state. Frame timing goes on underneath, and the line shows the frame again once break is released.
- R9: The line control fields are captured on the accepting edge. A change during a frame affects only later frames.
- R10: `busy` rises on the accepting edge and falls on the edge that ends the last stop tick. After that the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | Block is idle and can take a byte |
| in_data | input | 8 | Byte to send |
| lc_wlen | input | 2 | Character length select |
| lc_two_stop | input | 1 | Stop bit count select |
| lc_par_en | input | 1 | Parity bit enable |
| lc_par_type | input | 2 | Parity kind select |
| lc_break | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
Frames are sent at all four character lengths with data values whose upper bits are set. If the block sent the wrong bit count or bits in the wrong order, these frames would differ from the expected ones. One byte with an odd number of ones is sent under each of the four parity kinds, so swapping odd and even or the two stuck values shows up. Frames with long stop periods at lengths 8 and 5 separate the 32-tick and 24-tick cases. Other runs change the control fields in the middle of a frame, offer a byte while the block is busy, and pulse break both while idle and inside a frame. These runs show that the fields are captured at acceptance, that a byte offered while busy is dropped, and that break hides the line without moving the frame timing.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic [1:0] par_type;
  } lc_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // number of data bits for a length code
  function automatic logic [3:0] data_len(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  // parity bit for the given data, length and parity kind
  function automatic logic parity_bit(input logic [DATA_W-1:0] data,
                                      input logic [1:0] wlen,
                                      input logic [1:0] ptype);
    logic [DATA_W-1:0] mask;
    logic              ones_odd;
    mask     = {DATA_W{1'b1}} >> (3 - wlen);
    ones_odd = ^(data & mask);
    case (ptype)
      2'b00:   return ~ones_odd;
      2'b01:   return ones_odd;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // length of the stop period in ticks
  function automatic int stop_ticks(input logic [1:0] wlen,
                                    input logic two_stop,
                                    input int tpb);
    if (!two_stop)        return tpb;
    else if (wlen == 2'b00) return tpb + tpb / 2;
    else                  return 2 * tpb;
  endfunction

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter  int TICKS_PER_BIT = 16,
  localparam int TW = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          baud_tick,
  input  logic [TW-1:0] bit_len,
  output logic          bit_done
);

  logic [TW-1:0] tick_cnt;

  assign bit_done = run && baud_tick && (tick_cnt == bit_len - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tick_cnt <= '0;
    else if (!run || bit_done)   tick_cnt <= '0;
    else if (baud_tick)          tick_cnt <= tick_cnt + TW'(1);
  end

endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter  int TICKS_PER_BIT = 16,
  localparam int TW = $clog2(2 * TICKS_PER_BIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  lc_t               lc,
  input  logic              bit_done,
  output logic              busy,
  output logic              line_bit,
  output logic [TW-1:0]     bit_len,
  output logic              frame_done
);

  phase_t            phase;
  lc_t               lc_q;
  logic [DATA_W-1:0] shreg;
  logic [2:0]        bit_idx;
  logic              par_q;
  logic              last_data;

  assign busy       = (phase != PH_IDLE);
  assign frame_done = bit_done && (phase == PH_STOP);
  assign last_data  = ({1'b0, bit_idx} == data_len(lc_q.wlen) - 4'd1);

  always_comb begin
    if (phase == PH_STOP)
      bit_len = TW'(stop_ticks(lc_q.wlen, lc_q.two_stop, TICKS_PER_BIT));
    else
      bit_len = TW'(TICKS_PER_BIT);
  end

  always_comb begin
    case (phase)
      PH_START: line_bit = 1'b0;
      PH_DATA:  line_bit = shreg[0];
      PH_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      lc_q    <= '0;
      shreg   <= '0;
      bit_idx <= '0;
      par_q   <= 1'b0;
    end else if (accept) begin
      phase   <= PH_START;
      lc_q    <= lc;
      shreg   <= in_data;
      bit_idx <= '0;
      par_q   <= parity_bit(in_data, lc.wlen, lc.par_type);
    end else if (bit_done) begin
      case (phase)
        PH_START: phase <= PH_DATA;
        PH_DATA: begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 3'd1;
          if (last_data) phase <= lc_q.par_en ? PH_PAR : PH_STOP;
        end
        PH_PAR:   phase <= PH_STOP;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        lc_wlen,
  input  logic              lc_two_stop,
  input  logic              lc_par_en,
  input  logic [1:0]        lc_par_type,
  input  logic              lc_break,
  output logic              txd,
  output logic              busy
);

  localparam int TW = $clog2(2 * TICKS_PER_BIT + 1);

  lc_t           lc;
  logic          accept;
  logic          bit_done;
  logic          frame_done;
  logic          line_bit;
  logic [TW-1:0] bit_len;

  assign lc       = '{wlen: lc_wlen, two_stop: lc_two_stop,
                      par_en: lc_par_en, par_type: lc_par_type};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign txd      = lc_break ? 1'b0 : line_bit;

  uart_tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .baud_tick (baud_tick),
    .bit_len   (bit_len),
    .bit_done  (bit_done)
  );

  uart_tx_sequencer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .in_data    (in_data),
    .lc         (lc),
    .bit_done   (bit_done),
    .busy       (busy),
    .line_bit   (line_bit),
    .bit_len    (bit_len),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic in_ready,
  input logic accept,
  input logic lc_break,
  input logic txd,
  input logic busy,
  input logic bit_done,
  input logic frame_done
);

  // R2
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R10
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R10
  frame_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  // R8
  break_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_break |-> !txd);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lc_break) |-> txd);

  // R3
  bit_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> baud_tick);

  // R3
  line_holds_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(baud_tick) && !lc_break && !$past(lc_break))
      |-> $stable(txd));

endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .in_ready   (in_ready),
  .accept     (accept),
  .lc_break   (lc_break),
  .txd        (txd),
  .busy       (busy),
  .bit_done   (bit_done),
  .frame_done (frame_done)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;

  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] lc_wlen = 2'b00;
  logic       lc_two_stop = 1'b0;
  logic       lc_par_en = 1'b0;
  logic [1:0] lc_par_type = 2'b00;
  logic       lc_break = 1'b0;
  logic       txd;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_q[$];

  always #5 clk = ~clk;

  uart_frame_tx #(.TICKS_PER_BIT(TPB)) i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .lc_wlen(lc_wlen),
    .lc_two_stop(lc_two_stop), .lc_par_en(lc_par_en), .lc_par_type(lc_par_type),
    .lc_break(lc_break), .txd(txd), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // baud tick every third clock
  initial begin
    forever begin
      @(posedge clk); #1 baud_tick = 1'b1;
      @(posedge clk); #1 baud_tick = 1'b0;
      @(posedge clk);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  // monitor: one expected line level per tick while a frame runs
  always @(negedge clk) begin
    if (rst_n && baud_tick && busy) begin
      if (exp_q.size() == 0) begin
        check("R10 frame longer than expected", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        // R3 R8: line level per tick, masked by break
        check("R3 line level", txd, lc_break ? 1'b0 : e);
      end
    end
  end

  // build the expected tick stream from the requirements
  task automatic push_frame(input logic [7:0] d, input logic [1:0] wl, input bit two,
                            input bit pe, input logic [1:0] pt);
    int nb, ones, stop_t;
    bit p;
    nb = 5 + wl;
    ones = 0;
    for (int t = 0; t < TPB; t++) exp_q.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      ones += d[i];
      for (int t = 0; t < TPB; t++) exp_q.push_back(d[i]);
    end
    if (pe) begin
      case (pt)
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      for (int t = 0; t < TPB; t++) exp_q.push_back(p);
    end
    stop_t = !two ? TPB : (wl == 2'b00 ? TPB * 3 / 2 : 2 * TPB);
    for (int t = 0; t < stop_t; t++) exp_q.push_back(1'b1);
  endtask

  task automatic start_frame(input logic [7:0] d, input logic [1:0] wl, input bit two,
                             input bit pe, input logic [1:0] pt);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    push_frame(d, wl, two, pe, pt);
    @(posedge clk); #1;
    in_data = d; lc_wlen = wl; lc_two_stop = two; lc_par_en = pe; lc_par_type = pt;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data = 8'h00;
    @(negedge clk);
    // R10 busy right after the accepting edge, R2 ready falls
    check("R10 busy after accept", busy, 1);
    check("R2 ready low while busy", in_ready, 0);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    // R10 frame ended exactly after its last tick
    check("R10 no ticks left at end", exp_q.size(), 0);
    check("R1 idle line high", txd, 1);
    check("R1 ready when idle", in_ready, 1);
    exp_q.delete();
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input bit two,
                      input bit pe, input logic [1:0] pt);
    start_frame(d, wl, two, pe, pt);
    wait_done();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 txd reset", txd, 1);
    check("R1 busy reset", busy, 0);
    check("R1 ready reset", in_ready, 1);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", txd, 1);

    // R3 R4 lengths with high bits set
    send(8'hA5, 2'b11, 0, 0, 2'b00);
    send(8'hF3, 2'b00, 0, 0, 2'b00);
    send(8'hCE, 2'b01, 0, 0, 2'b00);
    send(8'hB9, 2'b10, 0, 0, 2'b00);

    // R5 R6 parity kinds on a byte with five ones
    send(8'h37, 2'b11, 0, 1, 2'b00);
    send(8'h37, 2'b11, 0, 1, 2'b01);
    send(8'h37, 2'b11, 0, 1, 2'b10);
    send(8'h37, 2'b11, 0, 1, 2'b11);
    send(8'hE6, 2'b10, 0, 1, 2'b01);

    // R7 stop periods
    send(8'h5A, 2'b11, 1, 0, 2'b00);
    send(8'h0B, 2'b00, 1, 1, 2'b00);
    send(8'h2D, 2'b01, 1, 0, 2'b00);

    // R2 byte offered while busy is dropped
    start_frame(8'h81, 2'b11, 0, 0, 2'b00);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'hFF;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R2 ready low under offer", in_ready, 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    check("R2 no frame from ignored byte", busy, 0);

    // R9 mid-frame field change has no effect on current frame
    start_frame(8'h96, 2'b00, 0, 0, 2'b00);
    @(posedge clk); #1;
    lc_wlen = 2'b11; lc_par_en = 1'b1; lc_two_stop = 1'b1; lc_par_type = 2'b10;
    wait_done();
    send(8'h96, 2'b11, 1, 1, 2'b10);

    // R8 break while idle
    @(posedge clk); #1 lc_break = 1'b1;
    @(negedge clk);
    check("R8 break idle", txd, 0);
    @(posedge clk); #1 lc_break = 1'b0;
    @(negedge clk);
    check("R8 release idle", txd, 1);

    // R8 break inside a frame, timing unchanged
    start_frame(8'h3C, 2'b11, 0, 1, 2'b01);
    repeat (60) @(posedge clk);
    #1 lc_break = 1'b1;
    repeat (90) @(posedge clk);
    #1 lc_break = 1'b0;
    wait_done();

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule